// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the read side of a two-wire serial memory. It watches a clock line and a data line and recognises start and stop conditions. After a start it takes in an address byte and decides whether the request is meant for it. It then serves bytes from a 512-word store, one per acknowledge from the master.

An internal word counter keeps the current position in the store. A write-direction header followed by one byte loads the counter, and a repeated start with a read header then streams from that position (random read). A read header on its own streams from wherever the counter already points (current-address read). The counter moves forward by itself after every byte, so a master that acknowledges each byte receives consecutive words. The counter wraps from the top of the store back to word zero.

Both lines pass through two-flop synchronizers on a fast system clock. The data line is an open-drain output: the slave never drives it high, it only asserts an enable that pulls the wire low. The stored words are computed from the address; there is no write path into the store.

Top module: `twi_seq_read_slave`

## Requirements
- R1: A start condition (data falls while the clock is high) begins a new header byte from any state, including partway through a byte. A stop condition (data rises while the clock is high) returns the slave to idle with the data line released. Out of reset the data line is released.
- R2: Header bits 7..2 are compared with the upper six bits of the `DEV_ID` parameter (default 6'b101000). Bit 0 is the direction, where 1 means read. On a match the slave pulls the data line low during the ninth clock.
- R3: If the header does not match, the slave gives no acknowledge and drives nothing until the next start condition. The word counter is left as it was.
- R4: A matching write-direction header followed by one word byte loads the counter with {header bit 1, word byte}, and the slave acknowledges the word byte. The next read then starts at that word.
- R5: A matching read header with no addressing before it returns the word at the current counter value.
- R6: Data leaves MSB first. The data line changes only while the clock is low. The word at address a is a[7:0] XOR 8'h5A, with every bit inverted when a[8] is 1.
- R7: The counter advances on the clock falling edge that ends the eighth data bit, whether or not the master then acknowledges.
- R8: The slave releases the data line during the master's acknowledge slot. When the master acknowledges, the slave sends the next word with no new addressing.
- R9: If the master leaves its acknowledge slot high and then sends a stop, the read ends with the data line released.
- R10: A streaming read that passes word 511 continues at word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | Pull the data line low when 1 |

## Verification
A wrong word counter shows up as a wrong data byte. This appears in the first byte of the next read, or when a read crosses the top of the store. An early or late counter step shifts every following byte by one word. A control state that goes astray shows up on the data line within one byte: a missing or extra acknowledge low, or the line held low where the master expects a released slot. Stop, nack and mismatch cases are followed by a current-address read, so a lost or extra counter step is visible at the pins.

// File: rtl/twi_rd_pkg.sv
package twi_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXDEV,
    ST_DEVACK,
    ST_RXWORD,
    ST_WORDACK,
    ST_TX,
    ST_MACK
  } rdState_t;

  typedef enum logic [1:0] {
    OE_NONE,
    OE_ACK,
    OE_DATA
  } oeSel_t;

  typedef struct packed {
    logic shiftIn;
    logic latchHdr;
    logic loadAddr;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } rdStrobe_t;

endpackage

// File: rtl/twi_rd_datapath.sv
module twi_rd_datapath
  import twi_rd_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [6:0] DEV_ID   = 7'b1010000,
  parameter logic [7:0] ROM_SEED = 8'h5A
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  rdStrobe_t strb,
  input  oeSel_t    oeSel,
  output logic      sclRise,
  output logic      sclFall,
  output logic      startDet,
  output logic      stopDet,
  output logic      sdaS,
  output logic      addrMatch,
  output logic      rwBit,
  output logic      sdaOe
);

  localparam int PAGE_W   = ADDR_W - 8;
  localparam int DEV_ID_W = 7 - PAGE_W;
  localparam int N_LINES  = 2;

  // Two-flop synchronizers plus one history stage per line
  logic [N_LINES-1:0] rawIn, meta, sync, prev;
  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta[g] <= 1'b1;
        sync[g] <= 1'b1;
        prev[g] <= 1'b1;
      end else begin
        meta[g] <= rawIn[g];
        sync[g] <= meta[g];
        prev[g] <= sync[g];
      end
    end
  end

  logic sclS, sclPrev, sdaPrev;
  assign sclS    = sync[0];
  assign sclPrev = prev[0];
  assign sdaS    = sync[1];
  assign sdaPrev = prev[1];

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // Receive shifter and captured header fields
  logic [7:0]        rxShift;
  logic [PAGE_W-1:0] pageReg;
  logic              rwReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      pageReg <= '0;
      rwReg   <= 1'b0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (strb.latchHdr) begin
        pageReg <= rxShift[PAGE_W:1];
        rwReg   <= rxShift[0];
      end
    end
  end

  assign addrMatch = (rxShift[7:8-DEV_ID_W] == DEV_ID[6:PAGE_W]);
  assign rwBit     = rwReg;

  // Word counter and transmit shifter
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0]        txShift;

  function automatic logic [7:0] wordAt(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ ROM_SEED ^ {8{^a[ADDR_W-1:8]}};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      txShift <= 8'hFF;
    end else begin
      if (strb.loadAddr)     addrCnt <= {pageReg, rxShift};
      else if (strb.incAddr) addrCnt <= addrCnt + 1'b1;
      if (strb.loadTx)       txShift <= wordAt(addrCnt);
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign sdaOe = (oeSel == OE_ACK) | ((oeSel == OE_DATA) & ~txShift[7]);

  // R6: the pull-down only changes while the synchronized clock is low
  assert_sda_low_phase_R6 : assert property (@(posedge clk) disable iff (!rstN)
    ((sdaOe != $past(sdaOe)) && !$past(startDet) && !$past(stopDet)) |-> !$past(sclS));

  // R7: the counter steps only at a clock falling edge
  assert_inc_on_fall_R7 : assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |-> sclFall);

endmodule

// File: rtl/twi_rd_ctrl.sv
module twi_rd_ctrl
  import twi_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaS,
  input  logic      addrMatch,
  input  logic      rwBit,
  output rdStrobe_t strb,
  output oeSel_t    oeSel
);

  localparam logic [3:0] BITS_IN  = 4'd8;
  localparam logic [3:0] LAST_OUT = 4'd7;

  rdState_t   state;
  logic [3:0] bitCnt;
  logic       masterAck;

  always_comb begin
    strb = '0;
    if (!startDet && !stopDet) begin
      unique case (state)
        ST_RXDEV: begin
          strb.shiftIn  = sclRise;
          strb.latchHdr = sclFall && (bitCnt == BITS_IN);
        end
        ST_RXWORD: begin
          strb.shiftIn  = sclRise;
          strb.loadAddr = sclFall && (bitCnt == BITS_IN);
        end
        ST_DEVACK: strb.loadTx = sclFall && rwBit;
        ST_TX: begin
          strb.shiftTx = sclFall && (bitCnt != LAST_OUT);
          strb.incAddr = sclFall && (bitCnt == LAST_OUT);
        end
        ST_MACK: strb.loadTx = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
      oeSel     <= OE_NONE;
    end else if (startDet) begin
      state  <= ST_RXDEV;
      bitCnt <= '0;
      oeSel  <= OE_NONE;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      oeSel  <= OE_NONE;
    end else begin
      unique case (state)
        ST_RXDEV, ST_RXWORD: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == BITS_IN) begin
            bitCnt <= '0;
            if (state == ST_RXWORD) begin
              state <= ST_WORDACK;
              oeSel <= OE_ACK;
            end else if (addrMatch) begin
              state <= ST_DEVACK;
              oeSel <= OE_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DEVACK: if (sclFall) begin
          bitCnt <= '0;
          if (rwBit) begin
            state <= ST_TX;
            oeSel <= OE_DATA;
          end else begin
            state <= ST_RXWORD;
            oeSel <= OE_NONE;
          end
        end
        ST_WORDACK: if (sclFall) begin
          state <= ST_IDLE;
          oeSel <= OE_NONE;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST_OUT) begin
            state  <= ST_MACK;
            oeSel  <= OE_NONE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) masterAck <= ~sdaS;
          else if (sclFall) begin
            if (masterAck) begin
              state <= ST_TX;
              oeSel <= OE_DATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: a start always rearms header reception from bit zero
  assert_start_rearms_R1 : assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RXDEV) && (bitCnt == 4'd0));

  // R9: a stop leaves the slave idle with the line released
  assert_stop_releases_R9 : assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE) && (oeSel == OE_NONE));

  // R3: the header acknowledge is only given to a matching header
  assert_ack_needs_match_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEVACK) |-> addrMatch);

endmodule

// File: rtl/twi_seq_read_slave.sv
module twi_seq_read_slave
  import twi_rd_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [6:0] DEV_ID   = 7'b1010000,
  parameter logic [7:0] ROM_SEED = 8'h5A
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  rdStrobe_t strb;
  oeSel_t    oeSel;
  logic      sclRise, sclFall, startDet, stopDet, sdaS, addrMatch, rwBit;

  twi_rd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .sdaS      (sdaS),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .strb      (strb),
    .oeSel     (oeSel)
  );

  twi_rd_datapath #(
    .ADDR_W   (ADDR_W),
    .DEV_ID   (DEV_ID),
    .ROM_SEED (ROM_SEED)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .oeSel     (oeSel),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .sdaS      (sdaS),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .sdaOe     (sdaOe)
  );

endmodule

// File: tb/tb_twi_seq_read_slave.sv
module tb_twi_seq_read_slave;

  localparam int         Q      = 8;
  localparam logic [5:0] DEV_HI = 6'b101000;
  localparam int         NVEC   = 5;
  // each entry: {byte count, start word}
  localparam logic [15:0] VEC [NVEC] = '{
    {7'd3, 9'h000}, {7'd4, 9'h0FE}, {7'd5, 9'h1FD}, {7'd1, 9'h0A7}, {7'd2, 9'h133}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;
  logic [8:0] expAddr = '0;

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  twi_seq_read_slave dut (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclDrv),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  function automatic logic [7:0] wordAt(input logic [8:0] a);
    return a[7:0] ^ 8'h5A ^ {8{a[8]}};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic phase();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; phase();
    sclDrv = 1'b1; phase();
    sdaDrv = 1'b0; phase();
    sclDrv = 1'b0; phase();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; phase();
    sclDrv = 1'b1; phase();
    sdaDrv = 1'b1; phase();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaDrv = b;    phase();
    sclDrv = 1'b1; phase();
    seen = sdaLine; phase();
    sclDrv = 1'b0; phase();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      v = {v[6:0], s};
    end
    clockBit(!giveAck, s);
  endtask

  task automatic randomRead(input logic [8:0] addr, input int n);
    bit a;
    logic [7:0] v;
    logic [8:0] w;
    startCond();
    sendByte({DEV_HI, addr[8], 1'b0}, a);
    check(a, "R2 write header ack", a, 1);
    sendByte(addr[7:0], a);
    check(a, "R4 word byte ack", a, 1);
    startCond();
    sendByte({DEV_HI, 1'b0, 1'b1}, a);
    check(a, "R2 read header ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, v);
      w = addr + 9'(k);
      if (k == 0)
        check(v == wordAt(w), "R4/R6 first word", v, wordAt(w));
      else if (32'(addr) + k > 511)
        check(v == wordAt(w), "R10 wrapped stream", v, wordAt(w));
      else
        check(v == wordAt(w), "R8 streamed word", v, wordAt(w));
    end
    stopCond();
    check(sdaOe == 1'b0, "R9 released after stop", sdaOe, 0);
    expAddr = addr + 9'(n);
  endtask

  task automatic currentRead(input string tag);
    bit a;
    logic [7:0] v;
    startCond();
    sendByte({DEV_HI, 1'b0, 1'b1}, a);
    check(a, "R2 current header ack", a, 1);
    recvByte(1'b0, v);
    check(v == wordAt(expAddr), tag, v, wordAt(expAddr));
    stopCond();
    expAddr = expAddr + 9'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic s;
    logic [7:0] v;
    repeat (10) @(negedge clk);
    check(sdaOe == 1'b0, "R1 reset release", sdaOe, 0);
    rstN = 1'b1;
    phase();
    check(sdaOe == 1'b0, "R1 idle release", sdaOe, 0);

    for (int i = 0; i < NVEC; i++) randomRead(VEC[i][8:0], int'(VEC[i][15:9]));

    // R5 current-address read, then R7 counter stepped despite the nack
    currentRead("R5 current-address word");
    currentRead("R7 step after nack");

    // R3 mismatching header: no ack, nothing driven, counter untouched
    startCond();
    sendByte({6'b101100, 1'b0, 1'b1}, a);
    check(!a, "R3 no ack on mismatch", a, 0);
    recvByte(1'b0, v);
    check(v == 8'hFF, "R3 line stays released", v, 8'hFF);
    stopCond();
    currentRead("R3 counter untouched");

    // R1 restart partway through the word byte abandons the load
    startCond();
    sendByte({DEV_HI, 1'b1, 1'b0}, a);
    check(a, "R1 header before abort", a, 1);
    for (int i = 0; i < 4; i++) clockBit(i[0], s);
    currentRead("R1 restart mid-byte");

    // R10 explicit top-of-store wrap
    randomRead(9'h1FF, 2);
    currentRead("R10 counter after wrap");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule